// File: doc/BRIEF.md
# Cascadable serial configuration memory sequencer

This block is the read-out side of a configuration memory that sends a stored bitstream to a device being loaded. Its contents are a fixed table computed when the design is elaborated. An address counter and a bit counter step forward on each rising clock edge while the part is selected, so the data always comes out in order. A strap picks the output width. In serial mode the part sends one bit per clock on `data_out[0]`. In byte-wide mode it sends one whole byte per clock.

Several of these parts can be chained. When a part has sent its last bit, the next clock edge makes it release its data output and pull its cascade-enable output low. The next part in the chain has that output wired to its own chip enable, so it then starts streaming from its first address. A shared reset/output-enable pin sends every part in the chain back to address zero. The active level of that pin comes from a strap, and the active-low setting is the usual one. The model does not use a real high-impedance driver. It shows a released bus as `data_oe` low with `data_out` forced to zero.

Top module: `cfg_stream_rom`

## Requirements
- R1: On a rising clock edge the counters advance only while `chip_en_n`=0, reset is inactive and the part is not exhausted. Stored data is presented strictly in ascending address order.
- R2: With `strap_byte_mode`=0 (serial), `data_out[0]` carries one bit per clock, most significant bit of each byte first, and `data_out[7:1]`=0. After bit 0 of a byte the bit counter wraps and the address increments.
- R3: With `strap_byte_mode`=1, `data_out[7:0]` carries the whole byte at the current address, and each clock moves on to the next address.
- R4: The clock edge that consumes the last stored bit or byte exhausts the part. From then on `data_oe`=0, `data_out`=0 and `cascade_en_n`=0, until the next reset.
- R5: A downstream part whose `chip_en_n` is driven by an upstream `cascade_en_n` stays released until the handoff. It then presents the data at its own address 0.
- R6: While `chip_en_n`=1 the part is in standby: `data_oe`=0 and `data_out`=0 whatever the reset pin does, and both counters hold.
- R7: Reset is active when `rst_oe` equals `strap_rst_pol`, so `strap_rst_pol`=0 gives an active-low pin. While reset is active, `data_oe`=0, `data_out`=0 and `cascade_en_n`=1. Any clock edge during reset clears the address, the bit counter and the exhausted state.
- R8: A reset applied after the part is exhausted brings `cascade_en_n` back to 1, and the next stream starts again from address 0, bit 7.
- R9: The stored byte at address a is ((a*37) mod 256) XOR 8'hA5.
- R10: After standby ends, streaming resumes at the exact bit or byte where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock supplied by the loading device |
| chip_en_n | input | 1 | Chip enable, active low; high selects standby |
| rst_oe | input | 1 | Combined reset / output-enable pin |
| strap_rst_pol | input | 1 | Level of `rst_oe` that means reset (0 = active low) |
| strap_byte_mode | input | 1 | 0 = serial one bit per clock, 1 = one byte per clock |
| data_out | output | 8 | Stream data; bit 0 only in serial mode |
| data_oe | output | 1 | High when the part drives `data_out` |
| cascade_en_n | output | 1 | Low once the part is exhausted, enabling the next part |

## Verification
The bench goes after the handoff edge with a second instance wired as the next part in the chain. A sequencer that was off by one there would either drop the final bit or let both parts drive the bus for a clock. It pauses a stream in the middle of a byte and then resumes it. A design whose counters drifted in standby would skip bits, and one that cleared the counters there would repeat data. It also covers the bit-order wrap at each byte boundary, both reset polarities, and a restart after exhaustion. Mistakes in these would show up as reversed bytes, a reset that never takes effect, or a cascade output stuck low.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    // Stored byte at address a: ((a*37) mod 256) xor A5h
    function automatic logic [7:0] image_byte(input int unsigned a);
        logic [31:0] prod;
        prod = a * 32'd37;
        return prod[7:0] ^ 8'hA5;
    endfunction

    typedef struct packed {
        logic [15:0] addr;
        logic [2:0]  bitn;
        logic        spent;
    } seq_state_t;

endpackage

// File: rtl/cfg_image_table.sv
module cfg_image_table
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);

    logic [7:0] image_w [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        assign image_w[gi] = image_byte(gi);
    end

    assign rd_byte = image_w[rd_addr];

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_act,
    input  logic          run,
    input  logic          byte_mode,
    output logic [AW-1:0] addr_q,
    output logic [2:0]    bitn_q,
    output logic          spent_q
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    seq_state_t st_d, st_q;
    logic at_last_addr, at_last_unit;

    assign at_last_addr = (st_q.addr[AW-1:0] == LAST_ADDR);
    assign at_last_unit = at_last_addr && (byte_mode || st_q.bitn == 3'd7);

    always_comb begin
        st_d = st_q;
        if (rst_act) begin
            st_d = '0;
        end else if (run) begin
            if (at_last_unit) begin
                st_d.spent = 1'b1;
            end else if (byte_mode || st_q.bitn == 3'd7) begin
                st_d.bitn = 3'd0;
                st_d.addr = st_q.addr + 16'd1;
            end else begin
                st_d.bitn = st_q.bitn + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr_q  = st_q.addr[AW-1:0];
    assign bitn_q  = st_q.bitn;
    assign spent_q = st_q.spent;

    // R1: byte mode steps exactly one address per enabled clock
    a_r1_byte_step: assert property (@(posedge clk) disable iff (rst_act)
        (run && byte_mode && !at_last_addr) |=> (addr_q == $past(addr_q) + 1'b1));

    // R2: serial mode steps the bit counter inside a byte, address unchanged
    a_r2_bit_step: assert property (@(posedge clk) disable iff (rst_act)
        (run && !byte_mode && bitn_q != 3'd7) |=> (bitn_q == $past(bitn_q) + 3'd1 && $stable(addr_q)));

    // R4: consuming the final unit exhausts the part on that edge
    a_r4_exhaust: assert property (@(posedge clk) disable iff (rst_act)
        (run && at_last_unit) |=> spent_q);

endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage (
    input  logic       drive,
    input  logic       byte_mode,
    input  logic [7:0] cur_byte,
    input  logic [2:0] bitn,
    output logic [7:0] data_out,
    output logic       data_oe
);

    logic serial_bit;

    always_comb begin
        serial_bit = cur_byte[3'd7 - bitn];
        data_out   = 8'h00;
        if (drive) begin
            data_out = byte_mode ? cur_byte : {7'b0, serial_bit};
        end
        data_oe = drive;
    end

endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       chip_en_n,
    input  logic       rst_oe,
    input  logic       strap_rst_pol,
    input  logic       strap_byte_mode,
    output logic [7:0] data_out,
    output logic       data_oe,
    output logic       cascade_en_n
);

    logic          rst_act;
    logic          run;
    logic [AW-1:0] addr_w;
    logic [2:0]    bitn_w;
    logic          spent_w;
    logic [7:0]    cur_byte;

    assign rst_act = (rst_oe == strap_rst_pol);
    assign run     = !rst_act && !chip_en_n && !spent_w;

    cfg_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_act   (rst_act),
        .run       (run),
        .byte_mode (strap_byte_mode),
        .addr_q    (addr_w),
        .bitn_q    (bitn_w),
        .spent_q   (spent_w)
    );

    cfg_image_table #(.DEPTH(DEPTH)) u_table (
        .rd_addr (addr_w),
        .rd_byte (cur_byte)
    );

    cfg_out_stage u_out (
        .drive     (run),
        .byte_mode (strap_byte_mode),
        .cur_byte  (cur_byte),
        .bitn      (bitn_w),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

    assign cascade_en_n = rst_act ? 1'b1 : !(spent_w && !chip_en_n);

    // R6: standby freezes both counters
    a_r6_standby_hold: assert property (@(posedge clk) disable iff (rst_act)
        chip_en_n |=> ($stable(addr_w) && $stable(bitn_w)));

    // R7: a clock in reset leaves counters and exhausted flag cleared
    a_r7_reset_clears: assert property (@(posedge clk)
        rst_act |=> (addr_w == '0 && bitn_w == 3'd0 && !spent_w));

    // R4: an exhausted part never drives data
    a_r4_release: assert property (@(posedge clk) disable iff (rst_act)
        spent_w |-> !data_oe);

endmodule

// File: tb/tb_cfg_stream_rom.sv
module tb_cfg_stream_rom;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       chip_en_n = 1'b1;
    logic       rst_oe = 1'b0;
    logic       strap_rst_pol = 1'b0;
    logic       strap_byte_mode = 1'b0;
    logic [7:0] data_out, data_out2;
    logic       data_oe, data_oe2;
    logic       cascade_en_n, cascade_en_n2;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cfg_stream_rom #(.DEPTH(DEPTH)) dut (
        .clk(clk), .chip_en_n(chip_en_n), .rst_oe(rst_oe),
        .strap_rst_pol(strap_rst_pol), .strap_byte_mode(strap_byte_mode),
        .data_out(data_out), .data_oe(data_oe), .cascade_en_n(cascade_en_n)
    );

    cfg_stream_rom #(.DEPTH(DEPTH)) dut_next (
        .clk(clk), .chip_en_n(cascade_en_n), .rst_oe(rst_oe),
        .strap_rst_pol(strap_rst_pol), .strap_byte_mode(strap_byte_mode),
        .data_out(data_out2), .data_oe(data_oe2), .cascade_en_n(cascade_en_n2)
    );

    function automatic logic [7:0] exp_byte(input int a);
        return 8'(((a * 37) % 256)) ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset(input logic pol, input logic bmode);
        @(negedge clk);
        strap_rst_pol   = pol;
        strap_byte_mode = bmode;
        chip_en_n       = 1'b1;
        rst_oe          = pol;
        tick();
        tick();
        rst_oe = ~pol;
        #1;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        strap_rst_pol = 1'b0;
        chip_en_n = 1'b0;
        rst_oe = 1'b0;
        tick();
        chk("R7 reset oe", {7'b0, data_oe}, 8'h00);
        chk("R7 reset data", data_out, 8'h00);
        chk("R7 reset cascade", {7'b0, cascade_en_n}, 8'h01);
        rst_oe = 1'b1;
        #1;
        chk("R7 release oe", {7'b0, data_oe}, 8'h01);
        chk("R2 first bit", data_out, {7'b0, exp_byte(0)[7]});
    endtask

    task automatic t_serial_chain();
        do_reset(1'b0, 1'b0);
        chip_en_n = 1'b0;
        #1;
        chk("R5 next idle", {7'b0, data_oe2}, 8'h00);
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < 8; b++) begin
                chk("R2 R9 serial bit", data_out, {7'b0, exp_byte(a)[7-b]});
                chk("R1 oe during stream", {7'b0, data_oe}, 8'h01);
                tick();
            end
        end
        chk("R4 released", {7'b0, data_oe}, 8'h00);
        chk("R4 data zero", data_out, 8'h00);
        chk("R4 cascade low", {7'b0, cascade_en_n}, 8'h00);
        chk("R5 next drives", {7'b0, data_oe2}, 8'h01);
        chk("R5 next first bit", data_out2, {7'b0, exp_byte(0)[7]});
        tick();
        chk("R5 next second bit", data_out2, {7'b0, exp_byte(0)[6]});
        chk("R4 stays released", {7'b0, data_oe}, 8'h00);
    endtask

    task automatic t_byte_stream();
        do_reset(1'b0, 1'b1);
        chip_en_n = 1'b0;
        #1;
        for (int a = 0; a < DEPTH; a++) begin
            chk("R3 R9 byte", data_out, exp_byte(a));
            tick();
        end
        chk("R4 byte exhausted", {7'b0, data_oe}, 8'h00);
        chk("R4 byte cascade", {7'b0, cascade_en_n}, 8'h00);
        chk("R5 next byte0", data_out2, exp_byte(0));
    endtask

    task automatic t_standby();
        do_reset(1'b0, 1'b0);
        chip_en_n = 1'b0;
        #1;
        tick(); tick(); tick();
        chip_en_n = 1'b1;
        #1;
        chk("R6 standby oe", {7'b0, data_oe}, 8'h00);
        chk("R6 standby data", data_out, 8'h00);
        rst_oe = 1'b0;
        tick();
        rst_oe = 1'b1;
        #1;
        chk("R6 standby ignores reset pin oe", {7'b0, data_oe}, 8'h00);
        for (int k = 0; k < 5; k++) tick();
        chip_en_n = 1'b0;
        #1;
        chk("R10 resume oe", {7'b0, data_oe}, 8'h01);
        // a low reset pin clocked during standby cleared the counters (R7)
        chk("R7 R10 resume bit", data_out, {7'b0, exp_byte(0)[7]});
        tick(); tick(); tick();
        chip_en_n = 1'b1;
        tick(); tick();
        chip_en_n = 1'b0;
        #1;
        chk("R10 resume mid byte", data_out, {7'b0, exp_byte(0)[4]});
        for (int k = 0; k < 5; k++) tick();
        chk("R2 wrap to next byte", data_out, {7'b0, exp_byte(1)[7]});
    endtask

    task automatic t_polarity();
        do_reset(1'b1, 1'b1);
        chip_en_n = 1'b0;
        #1;
        chk("R7 high pol run", data_out, exp_byte(0));
        tick();
        chk("R7 high pol step", data_out, exp_byte(1));
        rst_oe = 1'b1;
        #1;
        chk("R7 high pol reset oe", {7'b0, data_oe}, 8'h00);
        chk("R7 high pol cascade", {7'b0, cascade_en_n}, 8'h01);
        tick();
        rst_oe = 1'b0;
        #1;
        chk("R7 high pol cleared", data_out, exp_byte(0));
    endtask

    task automatic t_restart();
        do_reset(1'b0, 1'b1);
        chip_en_n = 1'b0;
        for (int a = 0; a < DEPTH; a++) tick();
        chk("R4 before restart", {7'b0, cascade_en_n}, 8'h00);
        rst_oe = 1'b0;
        #1;
        chk("R8 cascade back high", {7'b0, cascade_en_n}, 8'h01);
        tick();
        rst_oe = 1'b1;
        #1;
        chk("R8 restart oe", {7'b0, data_oe}, 8'h01);
        chk("R8 restart byte0", data_out, exp_byte(0));
        chk("R8 cascade high after", {7'b0, cascade_en_n}, 8'h01);
        strap_byte_mode = 1'b0;
        #1;
        chk("R8 restart serial bit7", data_out, {7'b0, exp_byte(0)[7]});
    endtask

    initial begin
        t_reset_state();
        t_serial_chain();
        t_byte_stream();
        t_standby();
        t_polarity();
        t_restart();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule